// File: doc/BRIEF.md
# Packet-Aware Stream FIFO with Store-and-Forward Option

This block is a single-clock FIFO placed between a valid/ready streaming producer and a valid/ready streaming consumer. Each beat holds a configurable number of symbols of a configurable symbol width. It also holds a channel number, an optional error field, and start and end markers that delimit packets. The sideband fields stay attached to their beat all the way through. Storage is a power-of-two ring buffer followed by one output register, so the total capacity is one beat more than the ring depth.

A build-time parameter selects one of two delivery modes. In cut-through mode a beat is offered downstream as soon as it has moved into the output register. In store-and-forward mode nothing is offered until the FIFO holds the closing beat of at least one packet, or until the FIFO has filled up. A full FIFO releases its contents so that a packet longer than the capacity cannot deadlock it. That release lasts until an end beat leaves the FIFO.

A small register port returns the current fill level and holds two thresholds. The thresholds drive the almost-full and almost-empty outputs. A second parameter chooses between using the reset pin directly and passing it through an internal synchronizer, so that reset is released in step with the clock.

Back-pressure rules are as follows. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. A beat is delivered on a rising edge where `out_valid` and `out_ready` are both high. Once `out_valid` is high, it stays high and the payload stays unchanged until the beat is taken. `in_ready` depends only on stored state, never on `in_valid`.

Top module: `pkt_sf_fifo`

## Requirements
- R1: The FIFO holds at most 2^DEPTH_LOG2 + 1 beats. `in_ready` is low exactly when that many beats are held, so no beat is ever overwritten or dropped.
- R2: Beats leave in the order they were accepted. Data, channel, error, start marker and end marker all arrive unchanged.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high on the next cycle and every output payload field keeps its value.
- R4: In cut-through mode, a beat accepted into an empty FIFO makes `out_valid` rise after the second rising edge following acceptance. After that, `out_valid` is high whenever a beat that was already held before the latest edge remains. It also applies to the store-and-forward gate, which holds beats back until R5 allows them.
- R5: In store-and-forward mode, `out_valid` is low unless one of three conditions holds. Either an accepted beat with `in_eop` set is still inside the FIFO, or the FIFO is full, or a full-release is pending. A full-release starts on any edge at which the FIFO was full, and ends when a beat with its end marker leaves.
- R6: A register read with `csr_addr` = 0 returns the number of beats held, counting the output register. The value is the count just before the read edge, zero-extended, and it appears on `csr_rdata` after that edge. `csr_rdata` keeps its value while `csr_read` is low.
- R7: An edge where a beat is accepted and a beat is delivered leaves the fill level unchanged.
- R8: The almost-full threshold is at `csr_addr` = 1 and the almost-empty threshold is at `csr_addr` = 2. Both are writable and readable, and each keeps the low ceil(log2(capacity+1)) bits of `csr_wdata`. Writes to addresses 0 and 3 have no effect, and address 3 reads as 0. A read and a write in the same cycle return the old value.
- R9: `almost_full` is high exactly when fill ≥ almost-full threshold. `almost_empty` is high exactly when fill ≤ almost-empty threshold.
- R10: After reset, `in_ready` is 1, `out_valid` is 0 and the fill level is 0. The almost-full threshold resets to 2^DEPTH_LOG2 and the almost-empty threshold resets to 1, so `almost_empty` is 1 and `almost_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Producer has a beat |
| in_ready | output | 1 | FIFO can accept a beat |
| in_data | input | BITS_PER_SYM*SYMS_PER_BEAT | Beat symbols |
| in_channel | input | CHAN_W | Channel number |
| in_error | input | max(ERR_W,1) | Error flags (ignored when ERR_W = 0) |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Beat offered downstream |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | BITS_PER_SYM*SYMS_PER_BEAT | Beat symbols |
| out_channel | output | CHAN_W | Channel number |
| out_error | output | max(ERR_W,1) | Error flags (0 when ERR_W = 0) |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| csr_addr | input | 2 | Register select |
| csr_write | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write value |
| csr_read | input | 1 | Register read strobe |
| csr_rdata | output | 32 | Registered read value |
| almost_full | output | 1 | Fill at or above upper threshold |
| almost_empty | output | 1 | Fill at or below lower threshold |

## Verification
Two instances run side by side, one in each mode, and each receives its own random traffic. The traffic varies in three ways: how often the producer offers a beat, how often the consumer takes one, and how often a beat closes a packet. Directed passes target specific behaviours:
- A lone beat into an empty FIFO separates the two-edge cut-through latency from the packet-gated path.
- A long run with no end markers and a stalled consumer fills both instances. It shows that only the full-release lets the store-and-forward instance drain.
- A short open packet, closed later, shows that beats are held back and then released.
- A pass with simultaneous accept and deliver, reading the fill register every cycle, shows that the count stays put.

Random threshold writes, including writes to the read-only and spare addresses, separate the stored thresholds from ignored writes through read-back and the two flag outputs.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    CSR_FILL   = 2'd0,
    CSR_AF_THR = 2'd1,
    CSR_AE_THR = 2'd2,
    CSR_SPARE  = 2'd3
  } csr_sel_e;

  localparam int CSR_DW = 32;

  function automatic int err_port_w(input int w);
    return (w > 0) ? w : 1;
  endfunction

endpackage

// File: rtl/sfc_rst_gen.sv
module sfc_rst_gen #(
  parameter bit ASYNC_RST = 1'b0,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  generate
    if (ASYNC_RST) begin : g_direct
      assign rst_ni = rst_n;
    end else begin : g_sync
      logic [SYNC_LEN-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_LEN-2:0], 1'b1};
      end
      assign rst_ni = chain_q[SYNC_LEN-1];
    end
  endgenerate

endmodule

// File: rtl/sfc_ring.sv
module sfc_ring #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         nonempty
);

  localparam int DEPTH = 1 << AW;

  logic [AW:0]  wp_q, rp_q;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
  end

  assign rd_data  = mem[rp_q[AW-1:0]];
  assign full     = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign nonempty = (wp_q != rp_q);

  AST_RING_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_ni)
    full |-> !wr_en); // R1
  AST_RING_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_ni)
    !nonempty |-> !rd_en); // R2

endmodule

// File: rtl/sfc_out_stage.sv
module sfc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);

  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= load_data;
      end else if (pop) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  AST_STAGE_POP_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> valid_q); // R3

endmodule

// File: rtl/sfc_csr.sv
module sfc_csr
  import sfc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [1:0]        addr,
  input  logic              write,
  input  logic [CSR_DW-1:0] wdata,
  input  logic              read,
  output logic [CSR_DW-1:0] rdata,
  input  logic [CNT_W-1:0]  fill,
  output logic              almost_full,
  output logic              almost_empty
);

  logic [CNT_W-1:0]  af_q, ae_q;
  logic [CSR_DW-1:0] rdata_q;
  csr_sel_e          sel;

  assign sel = csr_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q    <= CNT_W'(DEPTH);
      ae_q    <= CNT_W'(1);
      rdata_q <= '0;
    end else begin
      if (write) begin
        case (sel)
          CSR_AF_THR: af_q <= wdata[CNT_W-1:0];
          CSR_AE_THR: ae_q <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (read) begin
        case (sel)
          CSR_FILL:   rdata_q <= CSR_DW'(fill);
          CSR_AF_THR: rdata_q <= CSR_DW'(af_q);
          CSR_AE_THR: rdata_q <= CSR_DW'(ae_q);
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata        = rdata_q;
  assign almost_full  = (fill >= af_q);
  assign almost_empty = (fill <= ae_q);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !read |=> $stable(rdata)); // R6

endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo
  import sfc_pkg::*;
#(
  parameter int BITS_PER_SYM  = 8,
  parameter int SYMS_PER_BEAT = 4,
  parameter int DEPTH_LOG2    = 3,
  parameter int CHAN_W        = 2,
  parameter int ERR_W         = 2,
  parameter bit STORE_FWD     = 1'b1,
  parameter bit ASYNC_RST     = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [BITS_PER_SYM*SYMS_PER_BEAT-1:0] in_data,
  input  logic [CHAN_W-1:0]                    in_channel,
  input  logic [err_port_w(ERR_W)-1:0]         in_error,
  input  logic                                 in_sop,
  input  logic                                 in_eop,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [BITS_PER_SYM*SYMS_PER_BEAT-1:0] out_data,
  output logic [CHAN_W-1:0]                    out_channel,
  output logic [err_port_w(ERR_W)-1:0]         out_error,
  output logic                                 out_sop,
  output logic                                 out_eop,
  input  logic [1:0]                           csr_addr,
  input  logic                                 csr_write,
  input  logic [CSR_DW-1:0]                    csr_wdata,
  input  logic                                 csr_read,
  output logic [CSR_DW-1:0]                    csr_rdata,
  output logic                                 almost_full,
  output logic                                 almost_empty
);

  localparam int DATA_W = BITS_PER_SYM * SYMS_PER_BEAT;
  localparam int DEPTH  = 1 << DEPTH_LOG2;
  localparam int CAP    = DEPTH + 1;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int PW     = DATA_W + CHAN_W + ERR_W + 2;

  logic             rst_ni;
  logic [PW-1:0]    in_pay, ring_pay, out_pay;
  logic             mem_full, mem_nonempty;
  logic             stage_valid, load, push, pop, release_ok;
  logic [CNT_W-1:0] fill_q;

  sfc_rst_gen #(.ASYNC_RST(ASYNC_RST), .SYNC_LEN(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  generate
    if (ERR_W > 0) begin : g_err
      assign in_pay = {in_error, in_channel, in_sop, in_eop, in_data};
      assign {out_error, out_channel, out_sop, out_eop, out_data} = out_pay;
    end else begin : g_noerr
      assign in_pay    = {in_channel, in_sop, in_eop, in_data};
      assign {out_channel, out_sop, out_eop, out_data} = out_pay;
      assign out_error = '0;
    end
  endgenerate

  assign in_ready  = !mem_full;
  assign push      = in_valid && in_ready;
  assign out_valid = stage_valid && release_ok;
  assign pop       = out_valid && out_ready;
  assign load      = mem_nonempty && (!stage_valid || pop);

  sfc_ring #(.W(PW), .AW(DEPTH_LOG2)) u_ring (
    .clk(clk), .rst_ni(rst_ni),
    .wr_en(push), .wr_data(in_pay),
    .rd_en(load), .rd_data(ring_pay),
    .full(mem_full), .nonempty(mem_nonempty)
  );

  sfc_out_stage #(.W(PW)) u_stage (
    .clk(clk), .rst_ni(rst_ni),
    .load(load), .load_data(ring_pay), .pop(pop),
    .valid(stage_valid), .data(out_pay)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
    end else begin
      case ({push, pop})
        2'b10:   fill_q <= fill_q + CNT_W'(1);
        2'b01:   fill_q <= fill_q - CNT_W'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  generate
    if (STORE_FWD) begin : g_snf
      logic [CNT_W-1:0] eop_cnt_q;
      logic             flush_q;
      logic             eop_in, eop_out;

      assign eop_in  = push && in_eop;
      assign eop_out = pop && out_eop;

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          eop_cnt_q <= '0;
          flush_q   <= 1'b0;
        end else begin
          eop_cnt_q <= eop_cnt_q + CNT_W'(eop_in) - CNT_W'(eop_out);
          if (eop_out)                      flush_q <= 1'b0;
          else if (fill_q == CNT_W'(CAP))   flush_q <= 1'b1;
        end
      end

      assign release_ok = (eop_cnt_q != '0) || flush_q || (fill_q == CNT_W'(CAP));

      AST_SNF_HOLDBACK: assert property (@(posedge clk) disable iff (!rst_ni)
        (eop_cnt_q == '0 && !flush_q && fill_q != CNT_W'(CAP)) |-> !out_valid); // R5
    end else begin : g_cut
      assign release_ok = 1'b1;
    end
  endgenerate

  sfc_csr #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_csr (
    .clk(clk), .rst_ni(rst_ni),
    .addr(csr_addr), .write(csr_write), .wdata(csr_wdata),
    .read(csr_read), .rdata(csr_rdata),
    .fill(fill_q),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_q == CNT_W'(CAP)) |-> !in_ready); // R1
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_q <= CNT_W'(CAP)); // R1
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> out_valid); // R3
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> $stable(out_pay)); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (fill_q == '0) |-> !out_valid); // R4
  AST_FILL_SAME: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && pop) |=> $stable(fill_q)); // R7

endmodule

// File: tb/pkt_sf_fifo_tb.sv
`timescale 1ns/1ps
module pkt_sf_fifo_tb;

  localparam int BPS    = 8;
  localparam int SPB    = 4;
  localparam int DL2    = 3;
  localparam int CW     = 2;
  localparam int EW     = 2;
  localparam int DATA_W = BPS * SPB;
  localparam int DEPTH  = 1 << DL2;
  localparam int CAP    = DEPTH + 1;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int PW     = DATA_W + CW + EW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              iv[2], ir[2], isop[2], ieop[2];
  logic [DATA_W-1:0] idat[2], odat[2];
  logic [CW-1:0]     ich[2], och[2];
  logic [EW-1:0]     ierr[2], oerr[2];
  logic              ov[2], ordy[2], osop[2], oeop[2];
  logic [1:0]        caddr[2];
  logic              cwr[2], crd[2];
  logic [31:0]       cwd[2], crdata[2];
  logic              afl[2], aem[2];

  pkt_sf_fifo #(.BITS_PER_SYM(BPS), .SYMS_PER_BEAT(SPB), .DEPTH_LOG2(DL2),
                .CHAN_W(CW), .ERR_W(EW), .STORE_FWD(1'b1), .ASYNC_RST(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv[0]), .in_ready(ir[0]), .in_data(idat[0]), .in_channel(ich[0]),
    .in_error(ierr[0]), .in_sop(isop[0]), .in_eop(ieop[0]),
    .out_valid(ov[0]), .out_ready(ordy[0]), .out_data(odat[0]), .out_channel(och[0]),
    .out_error(oerr[0]), .out_sop(osop[0]), .out_eop(oeop[0]),
    .csr_addr(caddr[0]), .csr_write(cwr[0]), .csr_wdata(cwd[0]),
    .csr_read(crd[0]), .csr_rdata(crdata[0]),
    .almost_full(afl[0]), .almost_empty(aem[0])
  );

  pkt_sf_fifo #(.BITS_PER_SYM(BPS), .SYMS_PER_BEAT(SPB), .DEPTH_LOG2(DL2),
                .CHAN_W(CW), .ERR_W(EW), .STORE_FWD(1'b0), .ASYNC_RST(1'b1)) u_dut_ct (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv[1]), .in_ready(ir[1]), .in_data(idat[1]), .in_channel(ich[1]),
    .in_error(ierr[1]), .in_sop(isop[1]), .in_eop(ieop[1]),
    .out_valid(ov[1]), .out_ready(ordy[1]), .out_data(odat[1]), .out_channel(och[1]),
    .out_error(oerr[1]), .out_sop(osop[1]), .out_eop(oeop[1]),
    .csr_addr(caddr[1]), .csr_write(cwr[1]), .csr_wdata(cwd[1]),
    .csr_read(crd[1]), .csr_rdata(crdata[1]),
    .almost_full(afl[1]), .almost_empty(aem[1])
  );

  int checks = 0;
  int failures = 0;

  int k_v = 0, k_r = 0, k_e = 0, k_rd = 0, k_wr = 0, k_addr = -1;

  int          cnt[2], eopc[2], lastp[2], af[2], ae[2], rdaddr[2];
  bit          fl[2], rdp[2], hold[2];
  logic [31:0] rdexp[2];
  logic [PW-1:0] holdpay[2];
  logic [PW-1:0] q0[$];
  logic [PW-1:0] q1[$];

  function automatic logic [PW-1:0] pack_in(input int m);
    return {ierr[m], ich[m], isop[m], ieop[m], idat[m]};
  endfunction

  function automatic logic [PW-1:0] pack_out(input int m);
    return {oerr[m], och[m], osop[m], oeop[m], odat[m]};
  endfunction

  function automatic int qsize(input int m);
    return (m == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic [PW-1:0] qfront(input int m);
    return (m == 0) ? q0[0] : q1[0];
  endfunction

  function automatic bit exp_valid(input int m);
    bit gate;
    gate = (m == 1) || (eopc[m] > 0) || fl[m] || (cnt[m] == CAP);
    return ((cnt[m] - lastp[m]) > 0) && gate;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit            pu[2], po[2];
    logic [PW-1:0] pin[2], pout[2];
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      iv[m]    = ($urandom_range(0, 99) < k_v);
      idat[m]  = $urandom;
      ich[m]   = CW'($urandom);
      ierr[m]  = EW'($urandom);
      isop[m]  = 1'($urandom);
      ieop[m]  = ($urandom_range(0, 99) < k_e);
      ordy[m]  = ($urandom_range(0, 99) < k_r);
      crd[m]   = ($urandom_range(0, 99) < k_rd);
      cwr[m]   = ($urandom_range(0, 99) < k_wr);
      caddr[m] = (k_addr < 0) ? 2'($urandom_range(0, 3)) : 2'(k_addr);
      cwd[m]   = $urandom_range(0, 15);
    end
    #1;
    for (int m = 0; m < 2; m++) begin
      pout[m] = pack_out(m);
      pin[m]  = pack_in(m);
      chk(ir[m] == (cnt[m] < CAP), "R1", "in_ready", 64'(ir[m]), 64'(cnt[m] < CAP));
      chk(ov[m] == exp_valid(m), (m == 0) ? "R5" : "R4", "out_valid",
          64'(ov[m]), 64'(exp_valid(m)));
      if (ov[m] && qsize(m) > 0)
        chk(pout[m] == qfront(m), "R2", "payload order", 64'(pout[m]), 64'(qfront(m)));
      if (hold[m]) begin
        chk(ov[m] == 1'b1, "R3", "valid held", 64'(ov[m]), 64'd1);
        chk(pout[m] == holdpay[m], "R3", "payload held", 64'(pout[m]), 64'(holdpay[m]));
      end
      chk(afl[m] == (cnt[m] >= af[m]), "R9", "almost_full",
          64'(afl[m]), 64'(cnt[m] >= af[m]));
      chk(aem[m] == (cnt[m] <= ae[m]), "R9", "almost_empty",
          64'(aem[m]), 64'(cnt[m] <= ae[m]));
      if (rdp[m])
        chk(crdata[m] == rdexp[m], (rdaddr[m] == 0) ? "R6 R7" : "R8", "csr read",
            64'(crdata[m]), 64'(rdexp[m]));
      pu[m] = iv[m] && ir[m];
      po[m] = ov[m] && ordy[m];
    end
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      int            cb;
      logic [PW-1:0] popped;
      cb = cnt[m];
      rdp[m]    = crd[m];
      rdaddr[m] = int'(caddr[m]);
      case (caddr[m])
        2'd0:    rdexp[m] = 32'(cb);
        2'd1:    rdexp[m] = 32'(af[m]);
        2'd2:    rdexp[m] = 32'(ae[m]);
        default: rdexp[m] = 32'd0;
      endcase
      hold[m]    = ov[m] && !ordy[m];
      holdpay[m] = pout[m];
      popped     = '0;
      if (po[m] && qsize(m) > 0) begin
        popped = qfront(m);
        if (m == 0) void'(q0.pop_front()); else void'(q1.pop_front());
        cnt[m]--;
        if (popped[DATA_W]) eopc[m]--;
      end
      if (pu[m]) begin
        if (m == 0) q0.push_back(pin[m]); else q1.push_back(pin[m]);
        cnt[m]++;
        if (pin[m][DATA_W]) eopc[m]++;
      end
      if (po[m] && popped[DATA_W]) fl[m] = 1'b0;
      else if (cb == CAP)          fl[m] = 1'b1;
      lastp[m] = pu[m] ? 1 : 0;
      if (cwr[m]) begin
        if (caddr[m] == 2'd1) af[m] = int'(cwd[m][CNT_W-1:0]);
        if (caddr[m] == 2'd2) ae[m] = int'(cwd[m][CNT_W-1:0]);
      end
    end
  endtask

  task automatic set_k(input int v, input int r, input int e, input int rd,
                       input int wr, input int a);
    k_v = v; k_r = r; k_e = e; k_rd = rd; k_wr = wr; k_addr = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) begin
      iv[m] = 0; idat[m] = '0; ich[m] = '0; ierr[m] = '0; isop[m] = 0; ieop[m] = 0;
      ordy[m] = 0; caddr[m] = '0; cwr[m] = 0; cwd[m] = '0; crd[m] = 0;
      cnt[m] = 0; eopc[m] = 0; lastp[m] = 0; af[m] = DEPTH; ae[m] = 1;
      fl[m] = 0; rdp[m] = 0; hold[m] = 0; rdaddr[m] = 0; rdexp[m] = '0; holdpay[m] = '0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(ir[m] == 1'b1, "R10", "reset in_ready", 64'(ir[m]), 64'd1);
      chk(ov[m] == 1'b0, "R10", "reset out_valid", 64'(ov[m]), 64'd0);
      chk(aem[m] == 1'b1, "R10", "reset almost_empty", 64'(aem[m]), 64'd1);
      chk(afl[m] == 1'b0, "R10", "reset almost_full", 64'(afl[m]), 64'd0);
    end
    // R10 reset register values through read-back
    set_k(0, 0, 0, 100, 0, 1); repeat (2) step();
    set_k(0, 0, 0, 100, 0, 2); repeat (2) step();
    set_k(0, 0, 0, 100, 0, 0); repeat (2) step();
    set_k(0, 0, 0, 100, 0, 3); repeat (2) step();
    // R4 lone beat: two-edge latency in cut-through, closed packet in store-and-forward
    set_k(100, 0, 100, 0, 0, -1); step();
    set_k(0, 0, 0, 0, 0, -1); repeat (3) step();
    set_k(0, 100, 0, 0, 0, -1); repeat (4) step();
    // R1 R5 fill to capacity without end markers, then drain via full-release
    set_k(100, 0, 0, 20, 0, 0); repeat (14) step();
    set_k(0, 100, 0, 20, 0, 0); repeat (14) step();
    // R5 open packet held, then closed
    set_k(100, 100, 0, 0, 0, -1); repeat (3) step();
    set_k(0, 100, 0, 0, 0, -1); repeat (3) step();
    set_k(100, 100, 100, 0, 0, -1); step();
    set_k(0, 100, 0, 0, 0, -1); repeat (6) step();
    // R7 steady accept and deliver with fill read each cycle
    set_k(100, 0, 30, 0, 0, -1); repeat (4) step();
    set_k(100, 100, 30, 100, 0, 0); repeat (30) step();
    // R8 R9 random thresholds and traffic
    for (int b = 0; b < 30; b++) begin
      set_k($urandom_range(10, 100), $urandom_range(10, 100), $urandom_range(0, 60),
            30, 10, -1);
      repeat (100) step();
    end
    set_k(0, 100, 0, 0, 0, -1); repeat (20) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule